// File: doc/BRIEF.md
# Idle Link Pulse Transmit Sequencer

This block drives the transmit side of a 10 Mb/s twisted-pair port at the level of line codes. While a frame is being sent, it turns each data bit into a positive or negative drive code. When the frame ends, it sends a short positive end-of-frame marker. It then keeps the line silent, and after a fixed idle interval it issues a link test pulse. The pulse repeats at that interval for as long as no frame is sent. Pulse shaping, voltage levels and Manchester coding belong to the analog and encoder stages after this block.

The interval is counted in ticks of about 1 ms, taken from the system clock through a prescaler. The timer restarts from the start of each marker and from the start of each pulse. It is held cleared while a frame is on the line, so a frame that arrives in the middle of an interval cancels the pulse that was scheduled. A link-fail flag from the receive side blocks frame data. While it is set, the line stays in idle signalling and the link test pulses keep running. If the flag rises during a frame, that frame is cut short with a marker.

Top module: `lps_tx_sequencer`

## Requirements
- R1: While reset is high, and in the first cycle after it, `line_code_o` is silent (2'b00) and `pulse_stb_o` is 0.
- R2: In each cycle where `tx_en_i` is 1 and `link_fail_i` is 0, starting from idle or within a frame, the bit `tx_data_i` appears on `line_code_o` one clock later: 1 gives positive (2'b01) and 0 gives negative (2'b10).
- R3: When a frame ends (the send request goes away), `line_code_o` is positive for exactly MARK_CLKS clocks and then goes silent.
- R4: The first link test pulse starts exactly CLKS_PER_TICK*INTERVAL_TICKS clocks after the first cycle of the end-of-frame marker.
- R5: While the port stays idle, link test pulses repeat with exactly CLKS_PER_TICK*INTERVAL_TICKS clocks from the start of one pulse to the start of the next.
- R6: A link test pulse is a positive code held for exactly PULSE_CLKS clocks. `pulse_stb_o` is high for the first of those cycles only.
- R7: In idle, between the end of a marker or pulse and the start of the next pulse, `line_code_o` is silent.
- R8: While `link_fail_i` is 1, a send request is ignored: the line is never negative, it stays silent between pulses, and pulses keep their spacing. If the flag rises during a frame, that frame ends with a marker.
- R9: A frame that starts in the middle of an idle interval cancels the pending pulse. The next pulse is timed from the start of the marker that ends the frame.
- R10: After reset is released, the first pulse starts exactly CLKS_PER_TICK*INTERVAL_TICKS clocks later, provided no frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en_i | input | 1 | Request to send frame data |
| tx_data_i | input | 1 | Frame data bit for the next cycle |
| link_fail_i | input | 1 | Receive side reports that the link has failed |
| line_code_o | output | 2 | Drive code: 00 silent, 01 positive, 10 negative |
| pulse_stb_o | output | 1 | One-cycle strobe at the start of each link test pulse |

## Verification
The main data path is driven with a vector table. The table mixes ones and zeros, so a swapped polarity shows up. It ends a frame normally, which shows the marker length and the silence after it. It also raises link-fail both during idle and in the middle of a frame, which separates blocking a request from cutting a frame short. Pulse spacing is measured at the strobe in four situations: after a marker, between repeated pulses, while link-fail is held with a pending request, and after a frame that cancels a pending pulse. A design that times pulses from the wrong event gives a different distance in one of these cases. A reset in the middle of a run checks that the interval is timed again from reset release.

// File: rtl/lps_pkg.sv
package lps_pkg;

    // Drive code on the line
    typedef enum logic [1:0] {
        LC_SILENT = 2'b00,
        LC_POS    = 2'b01,
        LC_NEG    = 2'b10
    } line_code_e;

    // Sequencer state
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DATA  = 2'd1,
        ST_MARK  = 2'd2,
        ST_PULSE = 2'd3
    } seq_state_e;

    // Map one frame bit onto a drive code
    function automatic line_code_e bit_to_code(input logic b);
        return b ? LC_POS : LC_NEG;
    endfunction

    // Counter width for a count range of n (at least one bit)
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lps_prescaler.sv
module lps_prescaler
    import lps_pkg::*;
#(
    parameter int unsigned CLKS_PER_TICK = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int unsigned W = cnt_width(CLKS_PER_TICK);
    localparam logic [W-1:0] LAST = W'(CLKS_PER_TICK - 1);

    logic [W-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/lps_interval_timer.sv
module lps_interval_timer
    import lps_pkg::*;
#(
    parameter int unsigned INTERVAL_TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    output logic fire
);
    localparam int unsigned W = cnt_width(INTERVAL_TICKS);
    localparam logic [W-1:0] LAST = W'(INTERVAL_TICKS - 1);

    logic [W-1:0] ticks_q;

    assign fire = tick && (ticks_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ticks_q <= '0;
        end else if (fire) begin
            ticks_q <= '0;
        end else if (tick) begin
            ticks_q <= ticks_q + 1'b1;
        end
    end
endmodule

// File: rtl/lps_seq_fsm.sv
module lps_seq_fsm
    import lps_pkg::*;
#(
    parameter int unsigned PULSE_CLKS = 5,
    parameter int unsigned MARK_CLKS  = 13
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_en,
    input  logic       tx_data,
    input  logic       link_fail,
    input  logic       fire,
    output logic       tmr_clr,
    output line_code_e code,
    output logic       stb
);
    localparam int unsigned HMAX = (PULSE_CLKS > MARK_CLKS) ? PULSE_CLKS : MARK_CLKS;
    localparam int unsigned HW   = cnt_width(HMAX);
    localparam logic [HW-1:0] PULSE_LAST = HW'(PULSE_CLKS - 1);
    localparam logic [HW-1:0] MARK_LAST  = HW'(MARK_CLKS - 1);

    seq_state_e st_q, st_d;
    logic [HW-1:0] hold_q, hold_d;
    line_code_e code_q, code_d;
    logic stb_q, stb_d;
    logic go, start_pulse, start_mark;

    // A send request counts only while the link is good
    assign go = tx_en && !link_fail;

    always_comb begin
        st_d        = st_q;
        hold_d      = hold_q;
        code_d      = code_q;
        stb_d       = 1'b0;
        start_pulse = 1'b0;
        start_mark  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (go) begin
                    st_d   = ST_DATA;
                    code_d = bit_to_code(tx_data);
                end else if (fire) begin
                    st_d        = ST_PULSE;
                    code_d      = LC_POS;
                    stb_d       = 1'b1;
                    hold_d      = '0;
                    start_pulse = 1'b1;
                end else begin
                    code_d = LC_SILENT;
                end
            end
            ST_DATA: begin
                if (go) begin
                    code_d = bit_to_code(tx_data);
                end else begin
                    st_d       = ST_MARK;
                    code_d     = LC_POS;
                    hold_d     = '0;
                    start_mark = 1'b1;
                end
            end
            ST_MARK: begin
                if (hold_q == MARK_LAST) begin
                    st_d   = ST_IDLE;
                    code_d = LC_SILENT;
                end else begin
                    hold_d = hold_q + 1'b1;
                end
            end
            ST_PULSE: begin
                if (hold_q == PULSE_LAST) begin
                    st_d   = ST_IDLE;
                    code_d = LC_SILENT;
                end else begin
                    hold_d = hold_q + 1'b1;
                end
            end
            default: begin
                st_d   = ST_IDLE;
                code_d = LC_SILENT;
            end
        endcase
    end

    // Interval restarts at each marker or pulse; held cleared during a frame
    assign tmr_clr = (st_q == ST_DATA) || start_pulse || start_mark;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            hold_q <= '0;
            code_q <= LC_SILENT;
            stb_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            hold_q <= hold_d;
            code_q <= code_d;
            stb_q  <= stb_d;
        end
    end

    assign code = code_q;
    assign stb  = stb_q;
endmodule

// File: rtl/lps_tx_sequencer.sv
module lps_tx_sequencer
    import lps_pkg::*;
#(
    parameter int unsigned CLKS_PER_TICK  = 50000,
    parameter int unsigned INTERVAL_TICKS = 16,
    parameter int unsigned PULSE_CLKS     = 5,
    parameter int unsigned MARK_CLKS      = 13
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_en_i,
    input  logic       tx_data_i,
    input  logic       link_fail_i,
    output logic [1:0] line_code_o,
    output logic       pulse_stb_o
);
    logic       tick;
    logic       fire;
    logic       tmr_clr;
    line_code_e code;

    lps_prescaler #(
        .CLKS_PER_TICK(CLKS_PER_TICK)
    ) u_presc (
        .clk (clk),
        .rst (rst),
        .clr (tmr_clr),
        .tick(tick)
    );

    lps_interval_timer #(
        .INTERVAL_TICKS(INTERVAL_TICKS)
    ) u_timer (
        .clk (clk),
        .rst (rst),
        .clr (tmr_clr),
        .tick(tick),
        .fire(fire)
    );

    lps_seq_fsm #(
        .PULSE_CLKS(PULSE_CLKS),
        .MARK_CLKS (MARK_CLKS)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .tx_en    (tx_en_i),
        .tx_data  (tx_data_i),
        .link_fail(link_fail_i),
        .fire     (fire),
        .tmr_clr  (tmr_clr),
        .code     (code),
        .stb      (pulse_stb_o)
    );

    assign line_code_o = code;
endmodule

// File: rtl/lps_tx_sequencer_chk.sv
module lps_tx_sequencer_chk #(
    parameter int unsigned PERIOD = 800000
) (
    input logic       clk,
    input logic       rst,
    input logic       tx_en_i,
    input logic       tx_data_i,
    input logic       link_fail_i,
    input logic [1:0] line_code_o,
    input logic       pulse_stb_o,
    input logic       tmr_clr
);
    // Clocks since the interval timer was last restarted
    int unsigned gap_q;

    always_ff @(posedge clk) begin
        if (rst || tmr_clr) begin
            gap_q <= 1;
        end else if (gap_q <= PERIOD) begin
            gap_q <= gap_q + 1;
        end
    end

    // R4 / R5: a pulse starts exactly one interval after the last restart
    assert_interval_exact_R4: assert property (@(posedge clk) disable iff (rst)
        pulse_stb_o |-> ($past(gap_q) == PERIOD));

    // R6: the strobe marks a positive code
    assert_strobe_positive_R6: assert property (@(posedge clk) disable iff (rst)
        pulse_stb_o |-> (line_code_o == 2'b01));

    // R6: the strobe lasts a single cycle
    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (rst)
        pulse_stb_o |=> !pulse_stb_o);

    // R8: link fail never lets a negative data code through
    assert_fail_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        link_fail_i |=> (line_code_o != 2'b10));

    // R2: within a frame the next code follows the data bit
    assert_data_follow_R2: assert property (@(posedge clk) disable iff (rst)
        (line_code_o == 2'b10 && tx_en_i && !link_fail_i)
            |=> (line_code_o == ($past(tx_data_i) ? 2'b01 : 2'b10)));
endmodule

bind lps_tx_sequencer lps_tx_sequencer_chk #(
    .PERIOD(CLKS_PER_TICK * INTERVAL_TICKS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_en_i    (tx_en_i),
    .tx_data_i  (tx_data_i),
    .link_fail_i(link_fail_i),
    .line_code_o(line_code_o),
    .pulse_stb_o(pulse_stb_o),
    .tmr_clr    (tmr_clr)
);

// File: tb/lps_tx_sequencer_bench.sv
module lps_tx_sequencer_bench;
    localparam int CPT   = 4;
    localparam int ITV   = 5;
    localparam int PW    = 2;
    localparam int MW    = 3;
    localparam int N     = CPT * ITV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       dat = 1'b0;
    logic       fail = 1'b0;
    logic [1:0] code;
    logic       stb;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lps_tx_sequencer #(
        .CLKS_PER_TICK (CPT),
        .INTERVAL_TICKS(ITV),
        .PULSE_CLKS    (PW),
        .MARK_CLKS     (MW)
    ) u_lps_tx_sequencer (
        .clk        (clk),
        .rst        (rst),
        .tx_en_i    (en),
        .tx_data_i  (dat),
        .link_fail_i(fail),
        .line_code_o(code),
        .pulse_stb_o(stb)
    );

    // {en, dat, fail, expected code}; codes 00 silent, 01 positive, 10 negative
    localparam logic [4:0] VEC [0:14] = '{
        5'b1_1_0_01,  // R2 data one
        5'b1_0_0_10,  // R2 data zero
        5'b1_0_0_10,
        5'b1_1_0_01,
        5'b0_0_0_01,  // R3 marker
        5'b0_0_0_01,
        5'b0_0_0_01,
        5'b0_0_0_00,  // R3 silent after marker
        5'b1_1_1_00,  // R8 request blocked
        5'b1_0_1_00,
        5'b1_0_0_10,  // R2 new frame
        5'b1_1_1_01,  // R8 fail cuts frame, marker
        5'b0_0_0_01,
        5'b0_0_0_01,
        5'b0_0_0_00
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Wait for a strobe; count non-silent samples seen before it
    task automatic wait_stb(output int t, output int loud);
        loud = 0;
        t = -1;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (stb) begin
                t = cyc;
                return;
            end
            if (code != 2'b00) loud++;
        end
    endtask

    // Step through the rest of a pulse and check its width (R6)
    task automatic pulse_tail();
        chk("R6 strobe code", int'(code), 1);
        for (int k = 1; k < PW; k++) begin
            @(negedge clk);
            chk("R6 pulse held", int'(code), 1);
            chk("R6 strobe single", int'(stb), 0);
        end
        @(negedge clk);
        chk("R6 pulse end", int'(code), 0);
    endtask

    initial begin
        int t_mark, t1, t2, t3, t4, t5, t_r, loud;
        repeat (3) @(negedge clk);
        chk("R1 reset code", int'(code), 0);
        chk("R1 reset strobe", int'(stb), 0);
        rst = 1'b0;

        t_mark = 0;
        for (int i = 0; i < 15; i++) begin
            {en, dat, fail} = VEC[i][4:2];
            @(negedge clk);
            chk($sformatf("R2/R3/R8 vector %0d", i), int'(code), int'(VEC[i][1:0]));
            if (i == 11) t_mark = cyc;
        end
        en = 1'b0; dat = 1'b0; fail = 1'b0;

        // R4: first pulse timed from the marker start
        wait_stb(t1, loud);
        chk("R4 first pulse distance", t1 - t_mark, N);
        chk("R7 silence before pulse", loud, 0);
        pulse_tail();

        // R5: repeat spacing
        wait_stb(t2, loud);
        chk("R5 repeat distance", t2 - t1, N);
        chk("R7 silence between pulses", loud, 0);
        pulse_tail();

        // R8: link fail with a pending request
        fail = 1'b1; en = 1'b1; dat = 1'b0;
        wait_stb(t3, loud);
        chk("R8 pulses continue", t3 - t2, N);
        chk("R8 request ignored", loud, 0);
        pulse_tail();
        wait_stb(t4, loud);
        chk("R8 spacing kept", t4 - t3, N);
        chk("R8 line silent", loud, 0);
        pulse_tail();
        fail = 1'b0; en = 1'b0;

        // R9: frame in the middle of an interval
        repeat (6) @(negedge clk);
        en = 1'b1; dat = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 frame data", int'(code), 1);
        en = 1'b0;
        @(negedge clk);
        t_mark = cyc;
        wait_stb(t5, loud);
        chk("R9 pulse timed from marker", t5 - t_mark, N);
        pulse_tail();

        // R10: reset in the middle of a run restarts the interval
        repeat (5) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 mid-run reset code", int'(code), 0);
        rst = 1'b0;
        t_r = cyc;
        wait_stb(t1, loud);
        chk("R10 first pulse after reset", t1 - t_r, N);
        chk("R7 silence after reset", loud, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule